// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs the digital half of a dual-slope analogue-to-digital converter. An external integrator, comparator and analogue switch do the analogue work. The block sets the switch, clears the integrator, and counts system clocks. After a start pulse it clears the integrator for one clock. It then integrates the unknown input for a fixed run-up of 2^N clocks. At the end of run-up the counter wraps to zero and the integrator switches to the negative reference. The run-down phase counts clocks until the comparator reports that the integrator has returned to zero.

The run-down count, latched at that moment, is the conversion result. It is proportional to the ratio of the input to the reference. A conversion therefore takes about 2^N clocks plus the result value, which is slow next to a parallel-comparator converter but needs only one comparator. The comparator bit is synchronised before use, and the latched count is corrected for the synchroniser delay. A run-down that never ends within its full-scale window saturates the result and raises an overrange flag.

Top module: `dsadc_ctrl`

## Requirements
- R1: During and right after reset, sel_ref_o, int_clr_o, done_o and ovr_o are 0 and result_o is 0.
- R2: A start_i pulse seen while idle makes int_clr_o high for exactly one clock. It is followed by a run-up of exactly 2^CNT_W clocks with sel_ref_o low (0 = integrate the input).
- R3: sel_ref_o is 1 (integrate the negative reference) from the end of run-up until the conversion completes. It returns to 0 in the clock in which done_o is high.
- R4: For an input Vin and reference Vref with Vin < Vref, result_o is within one count of floor(2^CNT_W * Vin / Vref).
- R5: done_o is high for exactly one clock with each new result. result_o and ovr_o keep their values until the next done_o.
- R6: start_i pulses during a conversion are ignored. They start no new clear cycle, leave the run-up length unchanged and produce no extra done_o.
- R7: If the comparator has not fallen after 2^CNT_W run-down counts, the conversion ends with result_o all ones and ovr_o = 1. A later in-range conversion returns ovr_o to 0.
- R8: If the comparator is already low when run-down begins (zero input), result_o is 0.
- R9: The comparator input is not used during run-up, so a low comparator in that phase neither shortens nor ends the conversion.
- R10: cmp_i passes through a SYNC_STAGES-flop synchroniser. The synchroniser delay is subtracted from the latched count, so the result equals the number of run-down clocks in which the raw comparator was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the conversion time base |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, one clock, acted on only when idle |
| cmp_i | input | 1 | Comparator bit, high while integrator output is above zero; asynchronous |
| sel_ref_o | output | 1 | Integrator source select: 0 input voltage, 1 negative reference |
| int_clr_o | output | 1 | Integrator clear, high for one clock at the start of a conversion |
| result_o | output | CNT_W | Latched run-down count |
| done_o | output | 1 | One-clock strobe marking a new result |
| ovr_o | output | 1 | Overrange flag, valid with result_o |

## Verification
The bench models the integrator as a ramp that rises by Vin per clock in run-up and falls by Vref per clock in run-down. It drives the comparator from the sign of the ramp. Mid-scale and uneven ratios check the within-one proportionality and the exact latency-corrected count. A zero input shows the early-low comparator case. Ratios just below and at full scale separate the largest valid result from overrange, and a small input after an overrange shows that the flag clears. Two further runs force the comparator low during run-up and pulse start mid-conversion. Each must still give its normal result, run-up length and single strobe.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CLEAR = 2'd1,
      ST_RUNUP = 2'd2,
      ST_RUNDN = 2'd3
   } dsadc_state_e;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   output logic [W-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (en_i)  cnt_o <= cnt_o + 1'b1;
   end

   // the sequencer must stop or clear before the counter rolls over
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i) |-> (cnt_o != '1)) else $error("counter rollover"); // R7

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
   parameter int unsigned N        = 8,
   parameter int unsigned SYNC     = 2,
   parameter bit          LAT_COMP = 1'b1,
   localparam int unsigned CW      = N + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          sat_i,
   input  logic [CW-1:0] raw_i,
   output logic [N-1:0]  res_o,
   output logic          ovr_o,
   output logic          done_o
);

   logic [CW-1:0] adj;

   generate
      if (LAT_COMP) begin : g_comp
         assign adj = (raw_i < CW'(SYNC)) ? '0 : raw_i - CW'(SYNC);
      end else begin : g_raw
         assign adj = raw_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o  <= '0;
         ovr_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= load_i;
         if (load_i) begin
            ovr_o <= sat_i;
            res_o <= (sat_i || adj[CW-1]) ? '1 : adj[N-1:0];
         end
      end
   end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
   import dsadc_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LAT_COMP    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_i,
   output logic             sel_ref_o,
   output logic             int_clr_o,
   output logic [CNT_W-1:0] result_o,
   output logic             done_o,
   output logic             ovr_o
);

   localparam int unsigned CW       = CNT_W + 1;
   localparam int unsigned FULL     = 1 << CNT_W;
   localparam logic [CW-1:0] RU_LAST  = CW'(FULL - 1);
   localparam logic [CW-1:0] RD_LIMIT = LAT_COMP ? CW'(FULL - 1 + SYNC_STAGES)
                                                 : CW'(FULL - 1);

   initial begin
      AST_PARAM_WIDTH: assert (CNT_W >= 2 && CNT_W <= 24)
         else $error("CNT_W out of range"); // R2
      AST_PARAM_SYNC: assert (SYNC_STAGES >= 2 && SYNC_STAGES <= FULL)
         else $error("SYNC_STAGES out of range"); // R10
   end

   dsadc_state_e state_q, state_d;
   logic          cmp_s;
   logic [CW-1:0] cnt;
   logic          ru_end, rd_end, cnt_clr, cnt_en, load;

   dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   assign ru_end  = (state_q == ST_RUNUP) && (cnt == RU_LAST);
   assign rd_end  = (state_q == ST_RUNDN) && (!cmp_s || (cnt == RD_LIMIT));
   assign load    = rd_end;
   assign cnt_clr = (state_q == ST_CLEAR) || ru_end;
   assign cnt_en  = (state_q == ST_RUNUP) ||
                    ((state_q == ST_RUNDN) && cmp_s && (cnt != RD_LIMIT));

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start_i) state_d = ST_CLEAR;
         ST_CLEAR: state_d = ST_RUNUP;
         ST_RUNUP: if (ru_end) state_d = ST_RUNDN;
         ST_RUNDN: if (rd_end) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   dsadc_counter #(.W(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .en_i  (cnt_en),
      .cnt_o (cnt)
   );

   dsadc_result #(.N(CNT_W), .SYNC(SYNC_STAGES), .LAT_COMP(LAT_COMP)) u_res (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .sat_i  (cmp_s),
      .raw_i  (cnt),
      .res_o  (result_o),
      .ovr_o  (ovr_o),
      .done_o (done_o)
   );

   assign sel_ref_o = (state_q == ST_RUNDN);
   assign int_clr_o = (state_q == ST_CLEAR);

   AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      int_clr_o |=> (!int_clr_o && !sel_ref_o && cnt == '0)) else $error("clear"); // R2
   AST_RUNUP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_ref_o) |-> (cnt == '0)) else $error("no wrap"); // R3
   AST_SEL_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_ref_o) |-> done_o) else $error("sel end"); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done width"); // R5
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(ovr_o))) else $error("hold"); // R5
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q != ST_IDLE) |=> !int_clr_o) else $error("restart"); // R6
   AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovr_o) |-> (result_o == '1)) else $error("sat"); // R7
   AST_RUNUP_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUNUP && cnt != RU_LAST) |=> (state_q == ST_RUNUP)) else $error("runup"); // R9

endmodule

// File: tb/dsadc_ctrl_tb.sv
module dsadc_ctrl_tb;

   localparam int N    = 8;
   localparam int M    = 1 << N;
   localparam int SYNC = 2;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, cmp_i;
   logic sel_ref_o, int_clr_o, done_o, ovr_o;
   logic [N-1:0] result_o;

   longint vint = 0, vin = 0, vref = 1;
   logic   force_low = 1'b0;

   int total = 0, bad = 0, dones = 0, pushes = 0;

   typedef struct {
      int    res;
      bit    ovr;
      int    ideal;
      string tag;
   } exp_t;
   exp_t q[$];
   exp_t e;

   always #4 clk = ~clk;

   dsadc_ctrl #(.CNT_W(N), .SYNC_STAGES(SYNC), .LAT_COMP(1'b1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .cmp_i     (cmp_i),
      .sel_ref_o (sel_ref_o),
      .int_clr_o (int_clr_o),
      .result_o  (result_o),
      .done_o    (done_o),
      .ovr_o     (ovr_o)
   );

   // integrator and comparator model
   always @(posedge clk) begin
      if (int_clr_o)      vint <= 0;
      else if (sel_ref_o) vint <= vint - vref;
      else                vint <= vint + vin;
   end
   assign cmp_i = !force_low && (vint > 0);

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         dones++;
         if (q.size() == 0) begin
            chk(1'b0, "R6", "unexpected done", result_o, -1);
         end else begin
            e = q.pop_front();
            chk(ovr_o == e.ovr, e.ovr ? "R7" : "R7", {e.tag, " ovr"}, ovr_o, e.ovr);
            if (e.ovr) begin
               chk(result_o == '1, "R7", {e.tag, " saturate"}, result_o, M - 1);
            end else begin
               chk((int'(result_o) - e.ideal) inside {0, 1}, "R4",
                   {e.tag, " ratio"}, result_o, e.ideal);
               chk(int'(result_o) == e.res, "R10", {e.tag, " exact count"},
                   result_o, e.res);
            end
         end
      end
   end

   task automatic convert(input longint vi, input longint vr, input string tag,
                          input bit glitch, input bit restart);
      exp_t   x;
      longint k;
      int     ru, w, held;
      bit     sel_ok;
      logic [N-1:0] r;
      k       = (longint'(M) * vi + vr - 1) / vr;
      x.ideal = int'((longint'(M) * vi) / vr);
      x.ovr   = (k >= M);
      x.res   = x.ovr ? M - 1 : int'(k);
      x.tag   = tag;
      q.push_back(x);
      pushes++;
      vin  = vi;
      vref = vr;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk(int_clr_o == 1'b1, "R2", {tag, " clear cycle"}, int_clr_o, 1);
      ru = 0;
      forever begin
         @(negedge clk);
         if (sel_ref_o || ru > M + 8) break;
         chk(ru != 0 || int_clr_o == 1'b0, "R2", {tag, " clear width"}, int_clr_o, 0);
         ru++;
         start_i   = restart && (ru == 5);
         force_low = glitch && (ru >= 10) && (ru < 14);
      end
      start_i   = 1'b0;
      force_low = 1'b0;
      chk(ru == M, "R2", {tag, " runup length"}, ru, M);
      if (restart) begin
         start_i = 1'b1;
         @(negedge clk) start_i = 1'b0;
      end
      w = 0;
      sel_ok = 1'b1;
      while (!done_o && w < 4 * M) begin
         if (!sel_ref_o) sel_ok = 1'b0;
         @(negedge clk);
         w++;
      end
      chk(done_o == 1'b1, "R5", {tag, " completion"}, done_o, 1);
      chk(sel_ok && sel_ref_o == 1'b0, "R3", {tag, " source select"}, sel_ref_o, 0);
      r    = result_o;
      held = 1;
      repeat (6) begin
         @(negedge clk);
         if (done_o || result_o != r || int_clr_o) held = 0;
      end
      chk(held == 1, "R5", {tag, " hold after done"}, result_o, r);
      chk(dones == pushes, "R6", {tag, " done count"}, dones, pushes);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sel_ref_o == 0 && int_clr_o == 0 && done_o == 0 && ovr_o == 0 && result_o == 0,
          "R1", "reset outputs", {sel_ref_o, int_clr_o, done_o, ovr_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(result_o == 0 && done_o == 0, "R1", "after reset", result_o, 0);
      convert(100, 256, "mid", 1'b0, 1'b0);          // R4
      convert(37, 100, "uneven", 1'b0, 1'b0);        // R4 R10
      convert(0, 256, "zero", 1'b0, 1'b0);           // R8
      chk(result_o == 0, "R8", "zero input result", result_o, 0);
      convert(255, 256, "top valid", 1'b0, 1'b0);    // R7 boundary, no ovr
      convert(256, 256, "full", 1'b0, 1'b0);         // R7
      convert(500, 256, "over", 1'b0, 1'b0);         // R7
      convert(3, 256, "small", 1'b0, 1'b0);          // R7 flag clears
      chk(ovr_o == 0, "R7", "ovr cleared", ovr_o, 0);
      convert(50, 256, "runup glitch", 1'b1, 1'b0);  // R9
      convert(200, 256, "restart", 1'b0, 1'b1);      // R6
      chk(q.size() == 0, "R5", "all results seen", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog R5: actual=%0d expected=%0d", dones, pushes);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule